// File: doc/BRIEF.md
# Codec Clock, Frame Sync and Reset Sequencer

This block derives the serial bit clock and the 8 kHz frame sync for a PCM codec link from a fast base clock. With default parameters a 19.2 MHz base clock is divided by 75 into a 256 kHz bit clock. Thirty-two bit-clock periods make one 125 us frame. The frame sync is one bit-clock period wide and rises together with the bit clock.

The same block sequences reset and power-down for the surrounding device. Reset may arrive asynchronously. While reset is held, the codec clocks keep running, the serial data outputs are released to high impedance, and mode inputs are loaded continuously. After reset is released, the block waits for a fixed number of frames of initialisation before it tells downstream logic that input samples may be processed. Power-down stops both clocks low and silences everything. Leaving power-down restarts the clocks, but processing stays off until a fresh reset has been applied.

Top module: `codec_timing_seq`

## Requirements
- R1: The bit clock repeats every HIGH_CYC+LOW_CYC base cycles. Each period is high for HIGH_CYC cycles, then low for LOW_CYC cycles.
- R2: The frame sync is high for exactly one bit-clock period in every BITS_PER_FRAME bit-clock periods. Its rising and falling edges coincide with bit-clock rising edges.
- R3: Reset may be asserted asynchronously, and it has no effect on the bit clock or the frame sync. Processing and output enable drop at the first base-clock edge after reset is asserted.
- R4: The data output enable is low while reset is in effect. It goes high at the third base-clock edge after reset is released, which is when initialisation begins.
- R5: The processing-ready output rises on the INIT_FRAMES-th frame-sync rising edge, counting from the fourth base-clock edge after reset release. It stays low before that edge.
- R6: A reset applied during initialisation discards the frames already counted. After the next release, the full INIT_FRAMES wait is counted again.
- R7: Two base-clock edges after pwr_down_n is sampled low, the bit clock, frame sync, data output enable and processing-ready are all low, and they stay low.
- R8: After power-down is released, the bit clock and frame sync both go high at the second edge and then resume the R1 and R2 pattern. Enable and ready stay low until a reset has been applied and released.
- R9: ctrl_load is high during reset. During initialisation it is low. While processing, it pulses for one base cycle with each frame-sync rising edge, including the edge on which ready rises.
- R10: Power-down takes priority over reset. Toggling reset during power-down changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_base | input | 1 | Base clock (19.2 MHz by default) |
| rst_n_async | input | 1 | Asynchronous active-low reset |
| pwr_down_n | input | 1 | Active-low power-down request, sampled on clk_base |
| bit_clk | output | 1 | Codec serial bit clock |
| frame_sync | output | 1 | Frame sync, one bit-clock period wide |
| data_out_en | output | 1 | Drive enable for the serial data outputs (low means high impedance) |
| proc_ready | output | 1 | High when input samples may be processed |
| ctrl_load | output | 1 | Strobe telling downstream logic to latch its mode inputs |

## Verification
Assertions are checked on every cycle. They confirm that bit-clock edges fall on the divider wrap and half points, and that frame-sync edges coincide with bit-clock rising edges. They also confirm that readiness rises only on a frame boundary, that the wait counter stays in range, and that power-down keeps enable and ready low and outranks reset. Other behaviour can only be shown by the bench scenarios, run on a small configuration. These cover the exact readiness delay for every phase of reset release within a frame, restart of the wait after a reset during initialisation, the need for a fresh reset after power-down, and an unbroken clock pattern across reset assertions.

// File: rtl/codec_seq_pkg.sv
`timescale 1ns/1ps
package codec_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_DOWN  = 2'd0,
        SEQ_RESET = 2'd1,
        SEQ_INIT  = 2'd2,
        SEQ_RUN   = 2'd3
    } seq_state_e;

    // bit-clock level plus strobe marking the last base cycle of a period
    typedef struct packed {
        logic level;
        logic period_end;
    } bclk_s;

    // frame-sync level plus strobe marking the last base cycle of a frame
    typedef struct packed {
        logic sync;
        logic frame_end;
    } frame_s;

    function automatic int cntw(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/cs_ctrl_sync.sv
`timescale 1ns/1ps
module cs_ctrl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n_async,
    input  logic pwr_down_n,
    output logic rst_o,
    output logic pd_o
);
    logic [STAGES-1:0] sync_q;
    logic              pd_q;

    // assertion is immediate, release passes through STAGES flops
    always_ff @(posedge clk or negedge rst_n_async) begin
        if (!rst_n_async) sync_q <= '0;
        else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk) begin
        pd_q <= ~pwr_down_n;
    end

    assign rst_o = ~sync_q[STAGES-1];
    assign pd_o  = pd_q;
endmodule

// File: rtl/cs_bitclk_gen.sv
`timescale 1ns/1ps
module cs_bitclk_gen
    import codec_seq_pkg::*;
#(
    parameter int HIGH_CYC = 38,
    parameter int LOW_CYC  = 37
) (
    input  logic  clk,
    input  logic  pd_i,
    output bclk_s bclk_o
);
    localparam int DIV = HIGH_CYC + LOW_CYC;
    localparam int CW  = cntw(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HI_L = CW'(HIGH_CYC);

    logic [CW-1:0] cnt_q, cnt_nxt;
    logic          lvl_q;

    always_comb cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

    // parked on LAST so the first running cycle starts a fresh high phase
    always_ff @(posedge clk) begin
        if (pd_i) begin
            cnt_q <= LAST;
            lvl_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            lvl_q <= (cnt_nxt < HI_L);
        end
    end

    assign bclk_o.level      = lvl_q;
    assign bclk_o.period_end = !pd_i && (cnt_q == LAST);

    p_rise_at_wrap_r1: assert property (@(posedge clk) disable iff (pd_i)
        $rose(lvl_q) |-> (cnt_q == '0));
    p_fall_at_half_r1: assert property (@(posedge clk) disable iff (pd_i)
        $fell(lvl_q) |-> (cnt_q == HI_L));
endmodule

// File: rtl/cs_frame_gen.sv
`timescale 1ns/1ps
module cs_frame_gen
    import codec_seq_pkg::*;
#(
    parameter int BITS = 32
) (
    input  logic   clk,
    input  logic   pd_i,
    input  bclk_s  bclk_i,
    output frame_s frame_o
);
    localparam int IW = cntw(BITS);
    localparam logic [IW-1:0] ILAST = IW'(BITS - 1);

    logic [IW-1:0] idx_q;
    logic          fs_q;

    always_ff @(posedge clk) begin
        if (pd_i) begin
            idx_q <= ILAST;
            fs_q  <= 1'b0;
        end else if (bclk_i.period_end) begin
            idx_q <= (idx_q == ILAST) ? '0 : idx_q + 1'b1;
            fs_q  <= (idx_q == ILAST);
        end
    end

    assign frame_o.sync      = fs_q;
    assign frame_o.frame_end = bclk_i.period_end && (idx_q == ILAST);

    p_fs_rise_on_bclk_r2: assert property (@(posedge clk) disable iff (pd_i)
        $rose(fs_q) |-> $rose(bclk_i.level));
    p_fs_fall_on_bclk_r2: assert property (@(posedge clk) disable iff (pd_i)
        $fell(fs_q) |-> $rose(bclk_i.level));
endmodule

// File: rtl/cs_seq_fsm.sv
`timescale 1ns/1ps
module cs_seq_fsm
    import codec_seq_pkg::*;
#(
    parameter int INIT_FRAMES = 800
) (
    input  logic clk,
    input  logic rst_i,
    input  logic pd_i,
    input  logic frame_tick_i,
    output logic data_en_o,
    output logic ready_o,
    output logic ctrl_load_o
);
    localparam int WW = cntw(INIT_FRAMES);
    localparam logic [WW-1:0] WLAST = WW'(INIT_FRAMES - 1);

    seq_state_e    st_q, st_nxt;
    logic [WW-1:0] wait_q, wait_nxt;
    logic          ctrl_q;

    always_comb begin
        st_nxt   = st_q;
        wait_nxt = '0;
        if (pd_i) begin
            st_nxt = SEQ_DOWN;
        end else if (rst_i) begin
            st_nxt = SEQ_RESET;
        end else begin
            case (st_q)
                SEQ_RESET: st_nxt = SEQ_INIT;
                SEQ_INIT: begin
                    wait_nxt = wait_q;
                    if (frame_tick_i) begin
                        if (wait_q == WLAST) st_nxt = SEQ_RUN;
                        else                 wait_nxt = wait_q + 1'b1;
                    end
                end
                default: st_nxt = st_q;   // RUN holds, DOWN waits for reset
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q   <= st_nxt;
        wait_q <= wait_nxt;
        ctrl_q <= (st_nxt == SEQ_RESET) || ((st_nxt == SEQ_RUN) && frame_tick_i);
    end

    assign ready_o     = (st_q == SEQ_RUN);
    assign data_en_o   = (st_q == SEQ_INIT) || (st_q == SEQ_RUN);
    assign ctrl_load_o = ctrl_q;

    p_ready_on_frame_r5: assert property (@(posedge clk) disable iff (rst_i || pd_i)
        $rose(ready_o) |-> $past(frame_tick_i));
    p_wait_range_r5: assert property (@(posedge clk) disable iff (rst_i || pd_i)
        (st_q == SEQ_INIT) |-> (wait_q <= WLAST));
    p_reset_drops_r6: assert property (@(posedge clk) disable iff (pd_i)
        $past(rst_i) |-> !ready_o);
    p_pd_quiet_r7: assert property (@(posedge clk) disable iff (!pd_i)
        $past(pd_i) |-> (!data_en_o && !ready_o));
    p_no_run_from_down_r8: assert property (@(posedge clk) disable iff (pd_i || rst_i)
        ($past(st_q) == SEQ_DOWN) |-> !ready_o);
    p_pd_over_reset_r10: assert property (@(posedge clk) disable iff (!pd_i)
        (rst_i && $past(pd_i)) |-> !data_en_o);
endmodule

// File: rtl/codec_timing_seq.sv
`timescale 1ns/1ps
module codec_timing_seq
    import codec_seq_pkg::*;
#(
    parameter int HIGH_CYC       = 38,
    parameter int LOW_CYC        = 37,
    parameter int BITS_PER_FRAME = 32,
    parameter int INIT_FRAMES    = 800,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk_base,
    input  logic rst_n_async,
    input  logic pwr_down_n,
    output logic bit_clk,
    output logic frame_sync,
    output logic data_out_en,
    output logic proc_ready,
    output logic ctrl_load
);
    logic   rst_int, pd_int;
    bclk_s  bclk;
    frame_s frm;

    cs_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk_base),
        .rst_n_async (rst_n_async),
        .pwr_down_n  (pwr_down_n),
        .rst_o       (rst_int),
        .pd_o        (pd_int)
    );

    cs_bitclk_gen #(.HIGH_CYC(HIGH_CYC), .LOW_CYC(LOW_CYC)) u_bclk (
        .clk    (clk_base),
        .pd_i   (pd_int),
        .bclk_o (bclk)
    );

    cs_frame_gen #(.BITS(BITS_PER_FRAME)) u_frame (
        .clk     (clk_base),
        .pd_i    (pd_int),
        .bclk_i  (bclk),
        .frame_o (frm)
    );

    cs_seq_fsm #(.INIT_FRAMES(INIT_FRAMES)) u_fsm (
        .clk          (clk_base),
        .rst_i        (rst_int),
        .pd_i         (pd_int),
        .frame_tick_i (frm.frame_end),
        .data_en_o    (data_out_en),
        .ready_o      (proc_ready),
        .ctrl_load_o  (ctrl_load)
    );

    assign bit_clk    = bclk.level;
    assign frame_sync = frm.sync;
endmodule

// File: tb/tb_codec_timing_seq.sv
`timescale 1ns/1ps
module tb_codec_timing_seq;
    localparam int HI   = 3;
    localparam int LO   = 2;
    localparam int BPF  = 4;
    localparam int WF   = 3;
    localparam int DIVB = HI + LO;
    localparam int FRM  = DIVB * BPF;

    logic clk = 1'b0;
    logic rst_n, pd_n;
    logic bit_clk, frame_sync, data_out_en, proc_ready, ctrl_load;

    int   checks = 0;
    int   errors = 0;
    int   ph = 0;
    bit   track = 0;
    bit   done = 0;
    logic prev_fs = 1'b0;
    bit   fs_rose = 0;

    always #2.5 clk = ~clk;

    codec_timing_seq #(
        .HIGH_CYC(HI), .LOW_CYC(LO), .BITS_PER_FRAME(BPF),
        .INIT_FRAMES(WF), .SYNC_STAGES(2)
    ) dut (
        .clk_base(clk), .rst_n_async(rst_n), .pwr_down_n(pd_n),
        .bit_clk(bit_clk), .frame_sync(frame_sync), .data_out_en(data_out_en),
        .proc_ready(proc_ready), .ctrl_load(ctrl_load)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // one base cycle; sample 1 ns after the rising edge
    task automatic step();
        int eb, ef;
        @(posedge clk);
        #1;
        fs_rose = frame_sync && !prev_fs;
        prev_fs = frame_sync;
        if (track) begin
            eb = ((ph % DIVB) < HI) ? 1 : 0;
            ef = ((ph % FRM) < DIVB) ? 1 : 0;
            chk(bit_clk == eb, "R1/R3 bit clock pattern", bit_clk, eb);
            chk(frame_sync == ef, "R2/R3 frame sync pattern", frame_sync, ef);
            ph++;
        end
    endtask

    // release reset and follow it until ready, or until abort_at frame rises
    task automatic release_and_wait(input int abort_at, input string tag);
        int n = 0;
        int rises = 0;
        int er;
        rst_n = 1'b1;
        while (n < 500) begin
            step();
            n++;
            if (n >= 4 && fs_rose) rises++;
            er = (rises >= WF) ? 1 : 0;
            chk(data_out_en == (n >= 3), {tag, " R4 enable"}, data_out_en, (n >= 3));
            chk(proc_ready == er, {tag, " R5 ready timing"}, proc_ready, er);
            chk(ctrl_load == ((n < 3) || er), {tag, " R9 load strobe"}, ctrl_load,
                ((n < 3) || er));
            if (abort_at > 0 && rises == abort_at) return;
            if (rises >= WF) return;
        end
    endtask

    task automatic run_frames(input int k);
        for (int i = 0; i < k * FRM; i++) begin
            step();
            chk(ctrl_load == fs_rose, "R9 load pulse in run", ctrl_load, fs_rose);
            chk(proc_ready == 1'b1, "R5 ready holds", proc_ready, 1);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        pd_n  = 1'b0;
        repeat (4) step();
        chk(bit_clk == 0, "R7 bit clock low", bit_clk, 0);
        chk(frame_sync == 0, "R7 frame sync low", frame_sync, 0);
        chk(data_out_en == 0, "R7 enable low", data_out_en, 0);
        chk(proc_ready == 0, "R7 ready low", proc_ready, 0);

        // R10: reset activity during power-down changes nothing
        rst_n = 1'b1;
        for (int i = 0; i < 30; i++) begin
            step();
            if (i == 12) rst_n = 1'b0;
            if (i == 20) rst_n = 1'b1;
            chk({bit_clk, frame_sync, data_out_en, proc_ready} == 4'b0,
                "R10 silent under power-down", {bit_clk, frame_sync, data_out_en, proc_ready}, 0);
        end

        // leave power-down with reset held
        rst_n = 1'b0;
        pd_n  = 1'b1;
        step();
        chk(bit_clk == 0, "R8 clock still parked", bit_clk, 0);
        step();
        chk(bit_clk == 1 && frame_sync == 1, "R8 clocks resume", {bit_clk, frame_sync}, 3);
        ph = 1;
        track = 1;
        for (int i = 0; i < 45; i++) begin
            step();
            chk(data_out_en == 0, "R4 enable low in reset", data_out_en, 0);
            chk(ctrl_load == 1, "R9 load during reset", ctrl_load, 1);
        end

        // every release phase within a frame
        for (int off = 0; off < FRM; off++) begin
            rst_n = 1'b0;
            repeat (off + 3) step();
            release_and_wait(0, "sweep");
            chk(proc_ready == 1, "R5 ready reached", proc_ready, 1);
            run_frames(1);
            rst_n = 1'b0;
            step();
            chk(proc_ready == 0 && data_out_en == 0, "R3 reset drops outputs",
                {proc_ready, data_out_en}, 0);
        end

        // R6: reset mid-initialisation restarts the count
        repeat (3) step();
        release_and_wait(2, "R6 first");
        rst_n = 1'b0;
        step();
        step();
        chk(proc_ready == 0, "R6 ready low after reset", proc_ready, 0);
        release_and_wait(0, "R6 restart");
        chk(proc_ready == 1, "R6 ready after full wait", proc_ready, 1);
        run_frames(1);

        // power-down from run
        track = 0;
        pd_n = 1'b0;
        step();
        step();
        chk({bit_clk, frame_sync, data_out_en, proc_ready} == 4'b0, "R7 quiet after two edges",
            {bit_clk, frame_sync, data_out_en, proc_ready}, 0);
        rst_n = 1'b0;
        repeat (5) step();
        chk({bit_clk, frame_sync, data_out_en, proc_ready, ctrl_load} == 5'b0,
            "R10 reset ignored in power-down",
            {bit_clk, frame_sync, data_out_en, proc_ready, ctrl_load}, 0);
        rst_n = 1'b1;
        repeat (3) step();

        // leave power-down without reset: no processing
        pd_n = 1'b1;
        step();
        step();
        chk(bit_clk == 1 && frame_sync == 1, "R8 clocks resume", {bit_clk, frame_sync}, 3);
        ph = 1;
        track = 1;
        for (int i = 0; i < 5 * FRM; i++) begin
            step();
            chk(data_out_en == 0 && proc_ready == 0, "R8 idle until reset",
                {data_out_en, proc_ready}, 0);
        end
        rst_n = 1'b0;
        repeat (3) step();
        release_and_wait(0, "R8 after reset");
        chk(proc_ready == 1, "R8 ready after fresh reset", proc_ready, 1);
        run_frames(1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule